// File: doc/BRIEF.md
# ADC Host Readback Controller

This block is the host side of a link to a 16-bit successive-approximation converter that runs in a four-wire, chip-select style serial mode with a busy indicator. It owns the convert line (`cnv_o`), the serial data input of the converter (`sdi_o`) and the serial clock (`sck_o`), and it watches the converter's serial output (`sdo_i`). `sdo_i` is pulled high whenever the converter releases it. The controller starts a conversion by raising the convert line while the select line is high. It drops the select line early in the conversion and then waits for the serial output to go from high to low, which marks the end of the conversion. It then clocks the result out and presents it as a parallel word with a one-cycle strobe.

All timing is counted in system clock cycles and set by parameters. These cover the serial clock half-period, the select hold after conversion start, the minimum and maximum conversion time, the acquisition time and the minimum spacing between conversion starts. `sdo_i` passes through a two-flop synchronizer before its falling edge is detected. Because of that latency, the word is captured on serial clock falling edges 2 to 17. Each bit the converter shifts out on one falling edge is taken on the next one. While `run_i` is high the block converts back to back. If no end-of-conversion edge arrives within the allowed window, it sets an error flag and abandons the conversion.

The state machine has six states:
- IDLE: convert line low, select high.
- LAUNCH: convert line high, select high, for `T_SDI_HOLD` cycles.
- CONV: select low, waiting for the falling edge of the serial output.
- READ: the serial clock runs for 17 falling edges.
- TERM: one cycle with select high and the convert line still high. This ends the read.
- ACQ: convert line low for `T_ACQ` cycles.

The transitions are:
- IDLE→LAUNCH when `run_i` is high and the start spacing is met.
- LAUNCH→CONV when the hold time has elapsed.
- CONV→READ on the detected falling edge.
- CONV→TERM on timeout.
- READ→TERM on the 17th falling edge.
- TERM→ACQ always.
- ACQ→IDLE when the acquisition time has elapsed.

Top module: `adc_rdbk_ctrl`

## Requirements
- R1: During and right after reset: `cnv_o`=0, `sdi_o`=1, `sck_o`=0, `sample_vld_o`=0, `conv_err_o`=0, `sample_o`=0.
- R2: A conversion starts with a rising edge of `cnv_o` while `sdi_o` is 1. `sdi_o` stays 1 for exactly `T_SDI_HOLD` cycles after that rise and is 0 in the next cycle, which is before `T_CONV_MIN`.
- R3: `sdi_o` is 0 only while `cnv_o` is 1. It stays 0 from its fall until the end of the read, so it is still 0 when the converter pulls `sdo_i` low.
- R4: `sck_o` is 0 whenever `cnv_o` is 0. A read starts only after a high-to-low transition of the synchronized `sdo_i` in CONV. Each read gives exactly 17 falling edges of `sck_o`, with a period of 2·`SCK_HALF` cycles.
- R5: The bit the converter presents after falling edge k (k = 1 to 16) goes to `sample_o` bit 16−k. The first bit is the MSB, `sample_o[15]`.
- R6: In the cycle after the 17th falling edge, `sdi_o` rises while `cnv_o` is still 1. `sample_vld_o` is 1 for exactly that one cycle, with the new `sample_o`. `cnv_o` falls in the following cycle.
- R7: Between one conversion and the next start, `cnv_o` stays low for at least `T_ACQ` cycles.
- R8: Consecutive rising edges of `cnv_o` are at least `T_CYC_MIN` cycles apart.
- R9: While `run_i` stays high, conversions repeat back to back, each yielding one valid sample, with no other input.
- R10: If no falling edge of `sdo_i` is seen within `T_CONV_MAX`+4 cycles of entering CONV, the block ends that conversion:
  - `conv_err_o` becomes 1 as `sdi_o` rises;
  - no serial clock edge is produced and no valid strobe is given;
  - `conv_err_o` stays 1 until the next rising edge of `cnv_o` clears it.
- R11: When `run_i` falls after a conversion has started, that conversion completes with exactly one valid strobe. The block then stays idle with `cnv_o`=0, and `sample_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Level request: convert while high |
| sdo_i | input | 1 | Converter serial output (pulled high when released) |
| cnv_o | output | 1 | Convert line to the converter |
| sdi_o | output | 1 | Select / read-terminate line to the converter |
| sck_o | output | 1 | Serial clock, idle low |
| sample_o | output | DATA_W | Last captured result, MSB first on the wire |
| sample_vld_o | output | 1 | One-cycle strobe with a new result |
| conv_err_o | output | 1 | Sticky timeout flag, cleared at the next conversion start |

## Verification
The assertions assume that `sdo_i` behaves like a compliant converter:
- it stays high from conversion start until the converter finishes;
- it falls once, no later than `T_CONV_MAX` cycles after `cnv_o` rises;
- after that it changes only after falling edges of `sck_o`;
- it returns high when `sdi_o` rises or `cnv_o` falls.

The bench keeps to this with a behavioural converter model that updates `sdo_i` on the inactive clock edge, with conversion times swept between `T_CONV_MIN` and `T_CONV_MAX`. It deliberately breaks the assumption only in one case, where the model never answers, to exercise the timeout. `run_i` is driven one time step after a rising clock edge, so the start decision never races with the state register.

// File: rtl/adc_rdbk_pkg.sv
package adc_rdbk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_CONV   = 3'd2,
        ST_READ   = 3'd3,
        ST_TERM   = 3'd4,
        ST_ACQ    = 3'd5
    } rd_state_t;

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/adc_cycle_cnt.sv
module adc_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SAT = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sck,
    output logic fall_now
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

    logic [HW-1:0] half_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            sck      <= 1'b0;
        end else if (!en) begin
            half_cnt <= '0;
            sck      <= 1'b0;
        end else if (half_cnt == HLAST) begin
            half_cnt <= '0;
            sck      <= ~sck;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // High in the cycle whose closing edge drives sck from 1 to 0
    assign fall_now = en && sck && (half_cnt == HLAST);

    // R4
    sck_fall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_now |=> !sck);
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_nxt
);
    logic [W-1:0] word;

    assign word_nxt = {word[W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= word_nxt;
        end
    end
endmodule

// File: rtl/adc_rdbk_ctrl.sv
module adc_rdbk_ctrl
    import adc_rdbk_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SCK_HALF   = 2,
    parameter int T_SDI_HOLD = 4,
    parameter int T_CONV_MIN = 50,
    parameter int T_CONV_MAX = 160,
    parameter int T_ACQ      = 40,
    parameter int T_CYC_MIN  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sdi_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              sample_vld_o,
    output logic              conv_err_o
);
    localparam int CONV_LIMIT = T_CONV_MAX + 4;
    localparam int NFALL      = DATA_W + 1;
    localparam int TMAX_A     = (CONV_LIMIT > T_ACQ) ? CONV_LIMIT : T_ACQ;
    localparam int TMR_MAX    = (TMAX_A > T_SDI_HOLD) ? TMAX_A : T_SDI_HOLD;
    localparam int TW         = $clog2(TMR_MAX + 1);
    localparam int CW         = $clog2(T_CYC_MIN + 1);
    localparam int FW         = $clog2(NFALL + 1);

    rd_state_t         state, state_nxt;
    logic [TW-1:0]     tmr;
    logic              tmr_clr;
    logic [CW-1:0]     cyc_cnt;
    logic              cyc_ok;
    logic [FW-1:0]     falls;
    logic              sdo_s, sdo_q, fall_det;
    logic              sck_en, fall_now, shift_en, last_fall;
    logic [DATA_W-1:0] word_nxt;
    logic              launch_go, timeout_hit;

    // ---------------- synchronizer and edge detect ----------------
    adc_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sdo_i),
        .q     (sdo_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdo_q <= 1'b1;
        else        sdo_q <= sdo_s;
    end

    assign fall_det = sdo_q & ~sdo_s;

    // ---------------- phase timer ----------------
    assign tmr_clr = (state_nxt != state);

    adc_cycle_cnt #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr)
    );

    // ---------------- start spacing counter ----------------
    assign launch_go = (state == ST_IDLE) && (state_nxt == ST_LAUNCH);
    assign cyc_ok    = (cyc_cnt >= CW'(T_CYC_MIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt <= CW'(T_CYC_MIN);
        end else if (launch_go) begin
            cyc_cnt <= '0;
        end else if (cyc_cnt != CW'(T_CYC_MIN)) begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    // ---------------- serial clock and capture ----------------
    assign sck_en = (state == ST_READ);

    adc_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sck_en),
        .sck      (sck_o),
        .fall_now (fall_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            falls <= '0;
        end else if (state != ST_READ) begin
            falls <= '0;
        end else if (fall_now) begin
            falls <= falls + 1'b1;
        end
    end

    assign shift_en  = fall_now && (falls != '0);
    assign last_fall = fall_now && (falls == FW'(NFALL - 1));

    adc_shift_in #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sdo_s),
        .word_nxt (word_nxt)
    );

    assign timeout_hit = (tmr == TW'(CONV_LIMIT - 1));

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (run_i && cyc_ok)                  state_nxt = ST_LAUNCH;
            ST_LAUNCH: if (tmr == TW'(T_SDI_HOLD - 1))       state_nxt = ST_CONV;
            ST_CONV: begin
                if (fall_det)         state_nxt = ST_READ;
                else if (timeout_hit) state_nxt = ST_TERM;
            end
            ST_READ:   if (last_fall)                        state_nxt = ST_TERM;
            ST_TERM:                                         state_nxt = ST_ACQ;
            ST_ACQ:    if (tmr == TW'(T_ACQ - 1))            state_nxt = ST_IDLE;
            default:                                         state_nxt = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_o        <= 1'b0;
            sdi_o        <= 1'b1;
            sample_o     <= '0;
            sample_vld_o <= 1'b0;
            conv_err_o   <= 1'b0;
        end else begin
            cnv_o        <= (state_nxt == ST_LAUNCH) || (state_nxt == ST_CONV) ||
                            (state_nxt == ST_READ)   || (state_nxt == ST_TERM);
            sdi_o        <= !((state_nxt == ST_CONV) || (state_nxt == ST_READ));
            sample_vld_o <= (state == ST_READ) && last_fall;
            if ((state == ST_READ) && last_fall) begin
                sample_o <= word_nxt;
            end
            if (launch_go) begin
                conv_err_o <= 1'b0;
            end else if ((state == ST_CONV) && (state_nxt == ST_TERM)) begin
                conv_err_o <= 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    // R2
    cnv_rise_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> sdi_o);

    // R2
    sdi_drop_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAUNCH) |-> (tmr < TW'(T_CONV_MIN)));

    // R3
    sdi_low_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdi_o |-> cnv_o);

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_o |-> !sck_o);

    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !sample_vld_o);

    // R6
    vld_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> (cnv_o && sdi_o));

    // R6
    vld_then_cnv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !cnv_o);

    // R8
    cnv_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> $past(cyc_ok));

    // R10
    err_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_err_o) |-> !sample_vld_o);
endmodule

// File: tb/tb_adc_rdbk_ctrl.sv
module tb_adc_rdbk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 2;
    localparam int T_SDI_HOLD = 3;
    localparam int T_CONV_MIN = 20;
    localparam int T_CONV_MAX = 30;
    localparam int T_ACQ      = 8;
    localparam int T_CYC_MIN  = 130;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        sdo = 1'b1;
    logic        cnv, sdi, sck, vld, err;
    logic [15:0] sample;

    adc_rdbk_ctrl #(
        .DATA_W(16), .SCK_HALF(SCK_HALF), .T_SDI_HOLD(T_SDI_HOLD),
        .T_CONV_MIN(T_CONV_MIN), .T_CONV_MAX(T_CONV_MAX),
        .T_ACQ(T_ACQ), .T_CYC_MIN(T_CYC_MIN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .sdo_i(sdo),
        .cnv_o(cnv), .sdi_o(sdi), .sck_o(sck),
        .sample_o(sample), .sample_vld_o(vld), .conv_err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural converter and reference model ----------------
    bit          respond = 1'b1;
    int          dev_st = 0;          // 0 idle, 1 converting, 2 reading, 3 released
    int          conv_left, nfall, age, low_cnt, cyc, last_rise, rise_cnt, vld_cnt, conv_idx;
    bit          had_conv = 1'b0, saw_fall = 1'b0, prev_term = 1'b0;
    logic [15:0] word;
    logic [15:0] src_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] last_exp = 16'h0;
    logic        p_cnv = 1'b0, p_sdi = 1'b1, p_sck = 1'b0;

    initial begin
        conv_left = 0; nfall = 0; age = 0; low_cnt = 0; cyc = 0;
        last_rise = 0; rise_cnt = 0; vld_cnt = 0; conv_idx = 0; word = '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit this_term;
            this_term = 1'b0;
            cyc++;
            // every clock: protocol rules
            chk(sdi || cnv, "R3", "sdi low while cnv low", int'(sdi), 1);
            chk(cnv || !sck, "R4", "sck active while cnv low", int'(sck), 0);

            if (cnv && !p_cnv) begin
                chk(sdi == 1'b1, "R2", "sdi at cnv rise", int'(sdi), 1);
                chk(err == 1'b0, "R10", "err cleared at start", int'(err), 0);
                if (had_conv) begin
                    chk(low_cnt >= T_ACQ, "R7", "cnv low time", low_cnt, T_ACQ);
                    chk(cyc - last_rise >= T_CYC_MIN, "R8", "start spacing",
                        cyc - last_rise, T_CYC_MIN);
                end
                had_conv  = 1'b1;
                last_rise = cyc;
                rise_cnt++;
                age       = 0;
                low_cnt   = 0;
                dev_st    = 1;
                nfall     = 0;
                saw_fall  = 1'b0;
                conv_left = T_CONV_MIN + ((conv_idx * 7) % (T_CONV_MAX - T_CONV_MIN + 1));
                conv_idx++;
                word = (src_q.size() != 0) ? src_q.pop_front() : 16'h0;
                if (respond) exp_q.push_back(word);
                sdo = 1'b1;
            end else if (cnv) begin
                age++;
                if (age == T_SDI_HOLD - 1)
                    chk(sdi == 1'b1, "R2", "sdi before hold end", int'(sdi), 1);
                if (age == T_SDI_HOLD)
                    chk(sdi == 1'b0, "R2", "sdi after hold end", int'(sdi), 0);
                if (dev_st == 1 && respond) begin
                    conv_left--;
                    if (conv_left == 0) begin
                        chk(sdi == 1'b0, "R3", "sdi at end of conversion", int'(sdi), 0);
                        sdo      = 1'b0;
                        dev_st   = 2;
                        saw_fall = 1'b1;
                    end
                end
                if (p_sck && !sck) begin
                    nfall++;
                    if (dev_st == 2) sdo = (nfall <= 16) ? word[16 - nfall] : 1'b1;
                end
                if (sdi && !p_sdi) begin
                    this_term = 1'b1;
                    sdo = 1'b1;
                    if (saw_fall) begin
                        chk(nfall == 17, "R4", "sck falls per read", nfall, 17);
                        chk(vld == 1'b1, "R6", "valid with sdi rise", int'(vld), 1);
                    end else begin
                        chk(err == 1'b1, "R10", "err at abandon", int'(err), 1);
                        chk(vld == 1'b0, "R10", "no valid on timeout", int'(vld), 0);
                        chk(nfall == 0, "R10", "no sck on timeout", nfall, 0);
                    end
                    dev_st = 3;
                end
            end else begin
                low_cnt++;
                if (p_cnv)
                    chk(prev_term, "R6", "cnv falls right after terminate", int'(prev_term), 1);
                dev_st = 0;
                sdo = 1'b1;
            end

            if (vld) begin
                vld_cnt++;
                if (exp_q.size() != 0) begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    last_exp = e;
                    chk(sample == e, "R5", "sample value", int'(sample), int'(e));
                end else begin
                    chk(1'b0, "R5", "unexpected valid", int'(sample), 0);
                end
            end
            prev_term = this_term;
            p_cnv = cnv;
            p_sdi = sdi;
            p_sck = sck;
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic run_one(input logic [15:0] v);
        int r0;
        src_q.push_back(v);
        r0 = rise_cnt;
        @(posedge clk); #1;
        run = 1'b1;
        while (rise_cnt == r0) begin
            @(posedge clk); #1;
        end
        run = 1'b0;
        idle_cycles(250);
    endtask

    initial begin
        logic [15:0] pats[6];
        int v0, r0;
        pats = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'h1234};

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cnv == 1'b0 && sdi == 1'b1 && sck == 1'b0, "R1", "lines in reset",
            int'({cnv, sdi, sck}), 3'b010);
        chk(vld == 1'b0 && err == 1'b0 && sample == 16'h0, "R1", "outputs in reset",
            int'({vld, err}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnv == 1'b0 && sdi == 1'b1 && sck == 1'b0 && vld == 1'b0, "R1",
            "lines after reset", int'({cnv, sdi, sck, vld}), 4'b0100);
        idle_cycles(5);

        // single conversions, one per pattern
        foreach (pats[i]) begin
            v0 = vld_cnt;
            run_one(pats[i]);
            chk(vld_cnt == v0 + 1, "R11", "one valid per request", vld_cnt - v0, 1);
        end
        chk(cnv == 1'b0, "R11", "idle after request drops", int'(cnv), 0);
        chk(sample == 16'h1234, "R11", "sample holds", int'(sample), 16'h1234);

        // back-to-back conversions
        v0 = vld_cnt;
        r0 = rise_cnt;
        src_q.push_back(16'hC0DE);
        src_q.push_back(16'h0F0F);
        src_q.push_back(16'hF00F);
        src_q.push_back(16'h5AA5);
        run = 1'b1;
        while (rise_cnt < r0 + 4) begin
            @(posedge clk); #1;
        end
        run = 1'b0;
        idle_cycles(300);
        chk(vld_cnt == v0 + 4, "R9", "back-to-back valid count", vld_cnt - v0, 4);
        chk(sample == 16'h5AA5, "R9", "last back-to-back sample", int'(sample), 16'h5AA5);

        // timeout: converter never answers
        respond = 1'b0;
        v0 = vld_cnt;
        run_one(16'h5555);
        chk(vld_cnt == v0, "R10", "no valid after timeout", vld_cnt - v0, 0);
        chk(err == 1'b1, "R10", "err sticky", int'(err), 1);
        chk(sample == 16'h5AA5, "R10", "sample untouched by timeout", int'(sample), 16'h5AA5);
        respond = 1'b1;
        run_one(16'h3C3C);
        chk(err == 1'b0, "R10", "err cleared by new conversion", int'(err), 0);
        chk(sample == 16'h3C3C, "R5", "sample after recovery", int'(sample), 16'h3C3C);
        chk(exp_q.size() == 0, "R5", "all expected samples seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule